// File: doc/BRIEF.md
# Exception Entry Sequencer

This block works out the processor state that exception entry produces. When a request arrives, it takes the exception kind, the faulting PC, a delay-slot flag, a TLB refill flag, a coprocessor number and the current Status, Cause and exception-base values. From these it computes the redirect target and the return address to save. It also says which save register takes that address: the general exception PC, the error PC or the debug PC. Last, it gives the updated Status and Cause words and the debug cause bit to set.

The block covers three groups of kinds:
- general exceptions and interrupts, including the TLB refill and cache error vectors;
- the non-maskable interrupt and soft reset;
- the debug entries.

All outputs are registered. One clock after a request, a single-cycle redirect strobe comes out. The register-file write enables pulse in the same cycle. The surrounding pipeline flushes on the strobe and writes the returned values into its control registers.

Top module: `exc_entry_seq`

## Requirements
- R1: A request with a supported kind gives `redirect_o` high in the next cycle only. A request with an unsupported kind (14, 29 or 31) gives no redirect, no write enable and no debug bit, and leaves `npc_o` unchanged. Without a request, no redirect follows.
- R2: The general kinds are 0–13, 15, 18, 22, 23, 24, 25 and 30. For these, the kind value is the cause code, and Cause[6:2] is overwritten with it.
- R3: For a general kind, the vector base is 0xBFC00200 when Status[22] (BEV) is set. Otherwise it is `ebase_i` shifted left by 10.
- R4: The general vector offset is 0x180 by default. An interrupt (kind 0) uses 0x200 when Cause[23] (IV) is set.
- R5: TLB load (kind 2) or TLB store (kind 3) uses offset 0x000 when `refill_i` is set and Status[1] (EXL) is clear. In every other case it uses 0x180.
- R6: Cache error (kind 30) uses offset 0x100 when BEV is set, and 0x20000100 when BEV is clear.
- R7: For a general kind with EXL clear, `epc_we_o` pulses. The saved PC is PC−4 with Cause[31] (BD)=1 when `dslot_i` is set, and PC with BD=0 otherwise. With EXL set, no save happens and BD is kept.
- R8: A general kind returns Status with EXL set and all other bits unchanged.
- R9: Coprocessor unusable (kind 11) also loads Cause[29:28] from `ce_i`.
- R10: NMI (kind 16) and soft reset (kind 17) pulse `errorepc_we_o` and save the PC, backed up by 4 in a delay slot. They set Status[2] (ERL) and BEV, and jump to 0xBFC00000. NMI also sets Status[19]; soft reset also sets Status[20].
- R11: The debug kinds are single step 19, debug interrupt 20, instruction break 21, breakpoint 26, data store break 27 and data load break 28. Each pulses `depc_we_o`, jumps to 0xBFC00480 and raises one bit of `dbg_set_o`: bit0 single step, bit1 breakpoint, bit2 data load break, bit3 data store break, bit4 instruction break, bit5 debug interrupt. Single step saves the PC unmodified. The other debug kinds save PC−4 in a delay slot. Status is returned unchanged.
- R12: An interrupt (kind 0) with `dbg_mode_i` high is handled as a debug interrupt.
- R13: NMI, soft reset and debug entries clear BD when EXL is clear and leave the exception code unchanged. When EXL is set, Cause is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request |
| kind_i | input | 5 | Exception kind |
| pc_i | input | XLEN | PC of the excepting instruction |
| dslot_i | input | 1 | Instruction is in a branch delay slot |
| refill_i | input | 1 | TLB miss was a refill (no matching entry) |
| ce_i | input | 2 | Coprocessor number for coprocessor unusable |
| dbg_mode_i | input | 1 | Core is already in debug mode |
| status_i | input | XLEN | Current Status word |
| cause_i | input | XLEN | Current Cause word |
| ebase_i | input | XLEN-10 | Exception base, bits above bit 9 |
| redirect_o | output | 1 | One-cycle redirect strobe |
| npc_o | output | XLEN | New PC |
| save_pc_o | output | XLEN | Return address to save |
| epc_we_o | output | 1 | Write general exception PC |
| errorepc_we_o | output | 1 | Write error PC |
| depc_we_o | output | 1 | Write debug PC |
| status_o | output | XLEN | Updated Status word |
| cause_o | output | XLEN | Updated Cause word |
| dbg_set_o | output | 6 | Debug cause bit to set, one-hot |

## Verification
The assertions assume that `req_i` is low during reset. They also assume that no request follows directly on the cycle after another, so every strobe can be traced back to exactly one request and its inputs one cycle earlier. The stimulus drives each request for one cycle and then idles for a cycle. It draws kinds mostly from the supported set, with a few unsupported values. Status, Cause, PC, exception base and the flags are randomized, so EXL, BEV, IV and the delay slot take both values. Directed cases pin down the refill-with-EXL, cache error, interrupt-in-debug and single-step-in-delay-slot corners.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned KIND_W = 5;
  localparam int unsigned DBG_W  = 6;

  typedef enum logic [1:0] {CLS_NONE, CLS_GEN, CLS_ERR, CLS_DBG} exc_cls_e;

  localparam logic [KIND_W-1:0] K_INT   = 5'd0;
  localparam logic [KIND_W-1:0] K_TLBL  = 5'd2;
  localparam logic [KIND_W-1:0] K_TLBS  = 5'd3;
  localparam logic [KIND_W-1:0] K_CPU   = 5'd11;
  localparam logic [KIND_W-1:0] K_NMI   = 5'd16;
  localparam logic [KIND_W-1:0] K_SRST  = 5'd17;
  localparam logic [KIND_W-1:0] K_DSS   = 5'd19;
  localparam logic [KIND_W-1:0] K_DINT  = 5'd20;
  localparam logic [KIND_W-1:0] K_DIB   = 5'd21;
  localparam logic [KIND_W-1:0] K_DBP   = 5'd26;
  localparam logic [KIND_W-1:0] K_DDBS  = 5'd27;
  localparam logic [KIND_W-1:0] K_DDBL  = 5'd28;
  localparam logic [KIND_W-1:0] K_CACHE = 5'd30;

  localparam int unsigned ST_EXL = 1;
  localparam int unsigned ST_ERL = 2;
  localparam int unsigned ST_NMI = 19;
  localparam int unsigned ST_SR  = 20;
  localparam int unsigned ST_BEV = 22;
  localparam int unsigned CA_EC  = 2;
  localparam int unsigned CA_IV  = 23;
  localparam int unsigned CA_CE  = 28;
  localparam int unsigned CA_BD  = 31;

  localparam int unsigned DB_DSS  = 0;
  localparam int unsigned DB_DBP  = 1;
  localparam int unsigned DB_DDBL = 2;
  localparam int unsigned DB_DDBS = 3;
  localparam int unsigned DB_DIB  = 4;
  localparam int unsigned DB_DINT = 5;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              dbg_mode_i,
  output exc_cls_e          cls_o,
  output logic [DBG_W-1:0]  dbg_set_o,
  output logic              is_nmi_o,
  output logic              is_dss_o
);
  always_comb begin
    cls_o     = CLS_NONE;
    dbg_set_o = '0;
    is_nmi_o  = 1'b0;
    is_dss_o  = 1'b0;
    case (kind_i)
      5'd0: begin
        if (dbg_mode_i) begin
          cls_o = CLS_DBG;
          dbg_set_o[DB_DINT] = 1'b1;
        end else begin
          cls_o = CLS_GEN;
        end
      end
      5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
      5'd11, 5'd12, 5'd13, 5'd15, 5'd18, 5'd22, 5'd23, 5'd24, 5'd25,
      5'd30: cls_o = CLS_GEN;
      K_NMI:  begin cls_o = CLS_ERR; is_nmi_o = 1'b1; end
      K_SRST: cls_o = CLS_ERR;
      K_DSS:  begin cls_o = CLS_DBG; dbg_set_o[DB_DSS] = 1'b1; is_dss_o = 1'b1; end
      K_DINT: begin cls_o = CLS_DBG; dbg_set_o[DB_DINT] = 1'b1; end
      K_DIB:  begin cls_o = CLS_DBG; dbg_set_o[DB_DIB] = 1'b1; end
      K_DBP:  begin cls_o = CLS_DBG; dbg_set_o[DB_DBP] = 1'b1; end
      K_DDBS: begin cls_o = CLS_DBG; dbg_set_o[DB_DDBS] = 1'b1; end
      K_DDBL: begin cls_o = CLS_DBG; dbg_set_o[DB_DDBL] = 1'b1; end
      default: cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter logic [XLEN-1:0] BOOT_GEN_VEC  = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC       = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC       = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] OFS_GEN       = 32'h0000_0180,
  parameter logic [XLEN-1:0] OFS_IRQ       = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFS_REFILL    = 32'h0000_0000,
  parameter logic [XLEN-1:0] OFS_CERR_BOOT = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_CERR_RUN  = 32'h2000_0100
) (
  input  exc_cls_e          cls_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              bev_i,
  input  logic              exl_i,
  input  logic              iv_i,
  input  logic              refill_i,
  input  logic [XLEN-11:0]  ebase_i,
  output logic [XLEN-1:0]   npc_o
);
  logic [XLEN-1:0] base, ofs;

  always_comb begin
    base = bev_i ? BOOT_GEN_VEC : {ebase_i, 10'b0};
    ofs  = OFS_GEN;
    if (kind_i == K_INT && iv_i)
      ofs = OFS_IRQ;
    else if ((kind_i == K_TLBL || kind_i == K_TLBS) && refill_i && !exl_i)
      ofs = OFS_REFILL;
    else if (kind_i == K_CACHE)
      ofs = bev_i ? OFS_CERR_BOOT : OFS_CERR_RUN;
  end

  always_comb begin
    case (cls_i)
      CLS_GEN: npc_o = base + ofs;
      CLS_ERR: npc_o = ERR_VEC;
      CLS_DBG: npc_o = DBG_VEC;
      default: npc_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned ISTEP = 4
) (
  input  exc_cls_e          cls_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              is_nmi_i,
  input  logic              is_dss_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              dslot_i,
  input  logic [1:0]        ce_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   cause_i,
  output logic [XLEN-1:0]   save_pc_o,
  output logic              epc_we_o,
  output logic              errorepc_we_o,
  output logic              depc_we_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o
);
  logic exl;
  assign exl = status_i[ST_EXL];

  // single step always resumes at the stepped instruction
  assign save_pc_o = (dslot_i && !is_dss_i) ? pc_i - XLEN'(ISTEP) : pc_i;

  always_comb begin
    epc_we_o      = 1'b0;
    errorepc_we_o = 1'b0;
    depc_we_o     = 1'b0;
    status_o      = status_i;
    cause_o       = cause_i;
    case (cls_i)
      CLS_GEN: begin
        status_o[ST_EXL] = 1'b1;
        cause_o[CA_EC +: KIND_W] = kind_i;
        if (kind_i == K_CPU) cause_o[CA_CE +: 2] = ce_i;
        if (!exl) begin
          epc_we_o       = 1'b1;
          cause_o[CA_BD] = dslot_i;
        end
      end
      CLS_ERR: begin
        errorepc_we_o    = 1'b1;
        status_o[ST_ERL] = 1'b1;
        status_o[ST_BEV] = 1'b1;
        if (is_nmi_i) status_o[ST_NMI] = 1'b1;
        else          status_o[ST_SR]  = 1'b1;
        if (!exl) cause_o[CA_BD] = 1'b0;
      end
      CLS_DBG: begin
        depc_we_o = 1'b1;
        if (!exl) cause_o[CA_BD] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter logic [XLEN-1:0] BOOT_GEN_VEC = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC      = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC      = 32'hBFC0_0480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              dslot_i,
  input  logic              refill_i,
  input  logic [1:0]        ce_i,
  input  logic              dbg_mode_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [XLEN-11:0]  ebase_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [XLEN-1:0]   save_pc_o,
  output logic              epc_we_o,
  output logic              errorepc_we_o,
  output logic              depc_we_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [DBG_W-1:0]  dbg_set_o
);
  exc_cls_e         cls;
  logic [DBG_W-1:0] dbg_set_d;
  logic             is_nmi, is_dss;
  logic [XLEN-1:0]  npc_d, save_d, status_d, cause_d;
  logic             epc_we_d, errorepc_we_d, depc_we_d;
  logic             take;

  exc_decode i_decode (
    .kind_i    (kind_i),
    .dbg_mode_i(dbg_mode_i),
    .cls_o     (cls),
    .dbg_set_o (dbg_set_d),
    .is_nmi_o  (is_nmi),
    .is_dss_o  (is_dss)
  );

  exc_vector #(
    .XLEN        (XLEN),
    .BOOT_GEN_VEC(BOOT_GEN_VEC),
    .ERR_VEC     (ERR_VEC),
    .DBG_VEC     (DBG_VEC)
  ) i_vector (
    .cls_i   (cls),
    .kind_i  (kind_i),
    .bev_i   (status_i[ST_BEV]),
    .exl_i   (status_i[ST_EXL]),
    .iv_i    (cause_i[CA_IV]),
    .refill_i(refill_i),
    .ebase_i (ebase_i),
    .npc_o   (npc_d)
  );

  exc_state #(.XLEN(XLEN)) i_state (
    .cls_i        (cls),
    .kind_i       (kind_i),
    .is_nmi_i     (is_nmi),
    .is_dss_i     (is_dss),
    .pc_i         (pc_i),
    .dslot_i      (dslot_i),
    .ce_i         (ce_i),
    .status_i     (status_i),
    .cause_i      (cause_i),
    .save_pc_o    (save_d),
    .epc_we_o     (epc_we_d),
    .errorepc_we_o(errorepc_we_d),
    .depc_we_o    (depc_we_d),
    .status_o     (status_d),
    .cause_o      (cause_d)
  );

  assign take = req_i && (cls != CLS_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      epc_we_o      <= 1'b0;
      errorepc_we_o <= 1'b0;
      depc_we_o     <= 1'b0;
      dbg_set_o     <= '0;
      npc_o         <= '0;
      save_pc_o     <= '0;
      status_o      <= '0;
      cause_o       <= '0;
    end else begin
      redirect_o    <= take;
      epc_we_o      <= take && epc_we_d;
      errorepc_we_o <= take && errorepc_we_d;
      depc_we_o     <= take && depc_we_d;
      dbg_set_o     <= take ? dbg_set_d : '0;
      if (take) begin
        npc_o     <= npc_d;
        save_pc_o <= save_d;
        status_o  <= status_d;
        cause_o   <= cause_d;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN    = 32,
  parameter logic [XLEN-1:0] ERR_VEC = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC = 32'hBFC0_0480
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [KIND_W-1:0] kind_i,
  input logic              dslot_i,
  input logic [XLEN-1:0]   status_i,
  input logic              redirect_o,
  input logic [XLEN-1:0]   npc_o,
  input logic              epc_we_o,
  input logic              errorepc_we_o,
  input logic              depc_we_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [DBG_W-1:0]  dbg_set_o
);
  a_r1_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(req_i));
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !redirect_o);
  a_r1_we_with_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epc_we_o || errorepc_we_o || depc_we_o || dbg_set_o != '0) |-> redirect_o);
  a_r1_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({epc_we_o, errorepc_we_o, depc_we_o}));
  a_r2_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |-> cause_o[CA_EC +: KIND_W] == $past(kind_i));
  a_r7_exl_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |-> !$past(status_i[ST_EXL]) && cause_o[CA_BD] == $past(dslot_i));
  a_r8_exl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |-> status_o[ST_EXL]);
  a_r10_err_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    errorepc_we_o |-> npc_o == ERR_VEC && status_o[ST_ERL] && status_o[ST_BEV]);
  a_r11_dbg_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depc_we_o |-> npc_o == DBG_VEC && $countones(dbg_set_o) == 1);
endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN   (XLEN),
  .ERR_VEC(ERR_VEC),
  .DBG_VEC(DBG_VEC)
) i_exc_entry_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .kind_i       (kind_i),
  .dslot_i      (dslot_i),
  .status_i     (status_i),
  .redirect_o   (redirect_o),
  .npc_o        (npc_o),
  .epc_we_o     (epc_we_o),
  .errorepc_we_o(errorepc_we_o),
  .depc_we_o    (depc_we_o),
  .status_o     (status_o),
  .cause_o      (cause_o),
  .dbg_set_o    (dbg_set_o)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam time TCK = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0;
  logic        dslot = 1'b0, refill = 1'b0, dbgm = 1'b0;
  logic [1:0]  ce = '0;
  logic [31:0] status = '0, cause = '0;
  logic [21:0] ebase = '0;

  logic        redirect, epc_we, errorepc_we, depc_we;
  logic [31:0] npc, save_pc, status_q, cause_q;
  logic [5:0]  dbg_set;

  int n_chk = 0, n_bad = 0;

  always #(TCK/2) clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .pc_i(pc),
    .dslot_i(dslot), .refill_i(refill), .ce_i(ce), .dbg_mode_i(dbgm),
    .status_i(status), .cause_i(cause), .ebase_i(ebase),
    .redirect_o(redirect), .npc_o(npc), .save_pc_o(save_pc),
    .epc_we_o(epc_we), .errorepc_we_o(errorepc_we), .depc_we_o(depc_we),
    .status_o(status_q), .cause_o(cause_q), .dbg_set_o(dbg_set)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 general, 2 error, 3 debug
  function automatic int cls_of(logic [4:0] k, logic dm);
    if (k == 0) return dm ? 3 : 1;
    if (k <= 13 || k == 15 || k == 18 || (k >= 22 && k <= 25) || k == 30) return 1;
    if (k == 16 || k == 17) return 2;
    if (k == 19 || k == 20 || k == 21 || (k >= 26 && k <= 28)) return 3;
    return 0;
  endfunction

  function automatic logic [5:0] dbg_of(logic [4:0] k);
    case (k)
      5'd19: return 6'b000001;
      5'd26: return 6'b000010;
      5'd28: return 6'b000100;
      5'd27: return 6'b001000;
      5'd21: return 6'b010000;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [31:0] gen_npc(logic [4:0] k, logic [31:0] st,
                                          logic [31:0] ca, logic rf, logic [21:0] eb);
    logic [31:0] base = st[22] ? 32'hBFC0_0200 : {eb, 10'b0};
    logic [31:0] ofs = 32'h180;
    if (k == 0 && ca[23]) ofs = 32'h200;
    else if ((k == 2 || k == 3) && rf && !st[1]) ofs = 32'h0;
    else if (k == 30) ofs = st[22] ? 32'h100 : 32'h2000_0100;
    return base + ofs;
  endfunction

  task automatic run(logic [4:0] k, logic [31:0] p, logic ds, logic rf, logic [1:0] c,
                     logic dm, logic [31:0] st, logic [31:0] ca, logic [21:0] eb);
    int cl = cls_of(k, dm);
    logic [31:0] e_npc, e_save, e_st, e_ca, prev_npc;
    logic [5:0] e_dbg;
    string tn;
    prev_npc = npc;
    kind = k; pc = p; dslot = ds; refill = rf; ce = c; dbgm = dm;
    status = st; cause = ca; ebase = eb; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    e_st = st; e_ca = ca; e_dbg = '0; e_save = ds ? p - 4 : p; e_npc = prev_npc;
    case (cl)
      1: begin
        e_npc = gen_npc(k, st, ca, rf, eb);
        e_st[1] = 1'b1;
        e_ca[6:2] = k;
        if (k == 11) e_ca[29:28] = c;
        if (!st[1]) e_ca[31] = ds;
      end
      2: begin
        e_npc = 32'hBFC0_0000;
        e_st[2] = 1'b1; e_st[22] = 1'b1;
        if (k == 16) e_st[19] = 1'b1; else e_st[20] = 1'b1;
        if (!st[1]) e_ca[31] = 1'b0;
      end
      3: begin
        e_npc = 32'hBFC0_0480;
        e_dbg = dbg_of(k);
        if (k == 19) e_save = p;
        if (!st[1]) e_ca[31] = 1'b0;
      end
      default: ;
    endcase
    if (cl == 0) begin
      check("R1 unsupported redirect", 32'(redirect), 0);
      check("R1 unsupported we", {29'b0, epc_we, errorepc_we, depc_we}, 0);
      check("R1 unsupported dbg", 32'(dbg_set), 0);
      check("R1 unsupported npc hold", npc, prev_npc);
    end else begin
      check("R1 redirect", 32'(redirect), 1);
      if (cl == 1) begin
        if (k == 30) tn = "R6 npc";
        else if (k == 2 || k == 3) tn = "R5 npc";
        else if (k == 0) tn = "R4 npc";
        else tn = "R3 npc";
        check(tn, npc, e_npc);
        check("R7 epc_we", 32'(epc_we), 32'(!st[1]));
        if (!st[1]) check("R7 save pc", save_pc, e_save);
        check("R8 status", status_q, e_st);
        check(k == 11 ? "R9 cause" : "R2 cause", cause_q, e_ca);
      end else if (cl == 2) begin
        check("R10 npc", npc, e_npc);
        check("R10 errorepc_we", 32'(errorepc_we), 1);
        check("R10 save pc", save_pc, e_save);
        check("R10 status", status_q, e_st);
        check("R13 cause", cause_q, e_ca);
      end else begin
        check("R11 npc", npc, e_npc);
        check("R11 depc_we", 32'(depc_we), 1);
        check("R11 save pc", save_pc, e_save);
        check(k == 0 ? "R12 dbg bit" : "R11 dbg bit", 32'(dbg_set), 32'(e_dbg));
        check("R11 status", status_q, e_st);
        check("R13 cause", cause_q, e_ca);
      end
    end
    @(negedge clk);
    check("R1 single pulse", 32'(redirect), 0);
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] kinds [29] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,18,22,23,24,25,30,
                                16,17,19,20,21,26,27,28};
    logic [4:0] bad_k [3] = '{14, 29, 31};
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset redirect", 32'(redirect), 0);
    check("R1 reset npc", npc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(5'd8, 32'h8000_1000, 1'b1, 0, 0, 0, 32'h0, 32'h0, 22'h20_0000);          // R7 slot
    run(5'd8, 32'h8000_1000, 1'b1, 0, 0, 0, 32'h2, 32'h0, 22'h20_0000);          // R7 EXL set
    run(5'd2, 32'h0040_0000, 1'b0, 1, 0, 0, 32'h0, 32'h0, 22'h20_0000);          // R5 refill
    run(5'd3, 32'h0040_0000, 1'b0, 1, 0, 0, 32'h2, 32'h0, 22'h20_0000);          // R5 EXL
    run(5'd30, 32'h1234, 1'b0, 0, 0, 0, 32'h40_0000, 32'h0, 22'h0);             // R6 BEV
    run(5'd30, 32'h1234, 1'b0, 0, 0, 0, 32'h0, 32'h0, 22'h20_0001);             // R6 run
    run(5'd0, 32'h1000, 1'b0, 0, 0, 0, 32'h0, 32'h80_0000, 22'h20_0000);        // R4 IV
    run(5'd0, 32'h1000, 1'b1, 0, 0, 1, 32'h0, 32'h8000_0000, 22'h20_0000);      // R12
    run(5'd11, 32'h2000, 1'b0, 0, 2'd3, 0, 32'h0, 32'h0, 22'h20_0000);          // R9
    run(5'd19, 32'h3000, 1'b1, 0, 0, 0, 32'h0, 32'h8000_0000, 22'h0);           // R11 step
    run(5'd16, 32'h4000, 1'b1, 0, 0, 0, 32'h0, 32'h8000_0000, 22'h0);           // R10 nmi
    run(5'd17, 32'h4000, 1'b0, 0, 0, 0, 32'h2, 32'h8000_0000, 22'h0);           // R10 sreset, R13
    run(5'd14, 32'h5000, 1'b0, 0, 0, 0, 32'h0, 32'h0, 22'h0);                   // R1 unsupported
    for (int i = 0; i < 400; i++) begin
      logic [4:0] k;
      if ($urandom_range(0, 15) == 0) k = bad_k[$urandom_range(0, 2)];
      else k = kinds[$urandom_range(0, 28)];
      run(k, {$urandom()} & 32'hFFFF_FFFC, 1'($urandom()), 1'($urandom()),
          2'($urandom()), ($urandom_range(0, 3) == 0), $urandom(), $urandom(),
          22'($urandom()));
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule